// File: doc/BRIEF.md
# Debug Halt Control Unit

This unit sits on a 32-bit register bus beside a small processor core and gives a debugger control over it. It holds a key-protected halt control and status register, a set of sticky debug event flags that are cleared by writing ones, and a monitor control word that arms vector catches and gates the watchpoint unit. Events from the core can halt it once debug is enabled. These events are a breakpoint, a watchpoint match, an external debug request, a hard fault and the release of core reset. The unit drives three plain control levels back to the core: halt, single-step and interrupt mask.

A debugger first enables debug through the control register. It can then halt the core, set the step bit, and release the core by clearing the halt bit. The core then runs one instruction and halts again. Two status bits record a retired instruction and a core reset. Both are cleared by a read. Every bus access completes in the cycle it is presented and the bus is never stalled: writes land at the next clock edge and read data is combinational. The unit carries no streaming data, so it has no valid/ready handshake.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After `rst_n` is released, every register reads zero and `halt_req`, `step_en`, `irq_mask` and `wpt_unit_en` are low.
- R2: A write to the control register (offset 0xC0) is applied only when `bus_wdata[31:16]` equals the `KEY` parameter (default 16'hA05F). Bits [3:0] then load enable (bit 0), halt (bit 1), step (bit 2) and interrupt mask (bit 3). Any other key leaves the register unchanged.
- R3: The control register reads bit 16 = `core_reg_ready` and bit 17 = `core_halted`, and reserved bits read zero. The event flags read at offset 0x00 in bits [4:0]. The monitor word at offset 0xCC keeps only bit 0 (reset catch), bit 10 (hard-fault catch) and bit 24 (watchpoint enable). Unmapped offsets read zero.
- R4: Bit 24 (retired) and bit 25 (reset) of the control register are sticky and clear when the register is read. A set in the same cycle wins over the clear, so a read while `core_reset` is held returns 1 again on the next read.
- R5: `halt_req`, `step_en` and `irq_mask` follow the halt, step and mask bits only while enable is 1. With enable at 0 the halt and mask bits drive nothing.
- R6: The event flags are captured only while enable is 1. Writing 1 to a flag at offset 0x00 clears that flag. If a flag is set and cleared in the same cycle, the set wins.
- R7: With debug enabled, `core_bkpt` sets flag bit 1 and `core_ext_req` sets flag bit 4. Each also sets the halt bit.
- R8: Monitor bit 24 drives `wpt_unit_en`. When it is 0, `core_wpt` neither sets flag bit 2 nor halts the core. When it is 1, `core_wpt` does both.
- R9: With monitor bit 0 and debug enabled, the cycle after `core_reset` falls sets the halt bit and flag bit 3.
- R10: With monitor bit 10 and debug enabled, `core_hardfault` sets the halt bit and flag bit 3.
- R11: `core_reset` clears the halt bit, and this takes priority over any event that would set it.
- R12: Single step works only when the core is halted and the step bit is set. A keyed write with enable 1, step 1 and halt 0 then arms a step. The next `core_retire` sets the halt bit and flag bit 0. Without an armed step, `core_retire` does not halt the core.
- R13: An accepted control write with bits 0 and 1 both set sets flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the debug logic |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| core_bkpt | input | 1 | Breakpoint hit |
| core_wpt | input | 1 | Watchpoint match |
| core_ext_req | input | 1 | External debug request |
| core_retire | input | 1 | Instruction retired |
| core_reset | input | 1 | Core held in reset |
| core_hardfault | input | 1 | Hard fault taken |
| core_halted | input | 1 | Core is in debug halt |
| core_reg_ready | input | 1 | Core register transfer complete |
| halt_req | output | 1 | Halt the core |
| step_en | output | 1 | Single-step mode |
| irq_mask | output | 1 | Mask external interrupts, tick and pended service call |
| wpt_unit_en | output | 1 | Watchpoint unit enable |

## Verification
The bench builds the unit with `ADDR_W` = 8 and keeps the default key and offsets. This shows that the offset parameters still decode when the address is narrower than the default. It also shows that the key compare depends only on the upper write half, not on the address width. Because the default key is kept, both accepted and rejected writes can be driven with known values. The narrow address also places the unmapped offset 0xC8 and the three mapped offsets in one small space.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int DW = 32;
  // control register bit positions
  localparam int CB_EN      = 0;
  localparam int CB_HALT    = 1;
  localparam int CB_STEP    = 2;
  localparam int CB_MASK    = 3;
  localparam int SB_READY   = 16;
  localparam int SB_HALTED  = 17;
  localparam int SB_RETIRED = 24;
  localparam int SB_RESET   = 25;
  // event flag positions
  localparam int FL_HREQ    = 0;
  localparam int FL_BKPT    = 1;
  localparam int FL_WPT     = 2;
  localparam int FL_VCATCH  = 3;
  localparam int FL_EXT     = 4;
  localparam int NUM_FLAGS  = 5;
  // monitor word bit positions
  localparam int MB_VC_RST  = 0;
  localparam int MB_VC_HF   = 10;
  localparam int MB_WPT_EN  = 24;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dbg_bus_decode.sv
module dbg_bus_decode
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HCSR_OFF = 'h0C0,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 'h000,
  parameter logic [ADDR_W-1:0] MON_OFF  = 'h0CC
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     ctrl_word,
  input  logic [DW-1:0]     flag_word,
  input  logic [DW-1:0]     mon_word,
  output logic              wr_ctrl,
  output logic              wr_flag,
  output logic              wr_mon,
  output logic              rd_ctrl,
  output logic [DW-1:0]     rdata
);
  localparam int NREG = 3;
  logic [NREG-1:0]     hit;
  logic [ADDR_W-1:0]   offs [NREG];
  logic [DW-1:0]       words [NREG];

  assign offs[0]  = HCSR_OFF;
  assign offs[1]  = FLAG_OFF;
  assign offs[2]  = MON_OFF;
  assign words[0] = ctrl_word;
  assign words[1] = flag_word;
  assign words[2] = mon_word;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = (bus_addr == offs[g]);
  end

  assign wr_ctrl = bus_sel &  bus_wr & hit[0];
  assign wr_flag = bus_sel &  bus_wr & hit[1];
  assign wr_mon  = bus_sel &  bus_wr & hit[2];
  assign rd_ctrl = bus_sel & ~bus_wr & hit[0];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata = rdata | words[i];
    end
  end
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_halt_pkg::*;
#(
  parameter logic [15:0] KEY = 16'hA05F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic          halt_evt,
  input  logic          core_reset,
  input  logic          core_retire,
  input  logic          core_halted,
  output ctrl_t         ctrl_q,
  output logic          hreq_evt,
  output logic          rst_sticky,
  output logic          ret_sticky
);
  logic  key_ok, release_step, step_pend, step_done;
  ctrl_t ctrl_d;

  assign key_ok = wr_en && (wdata[DW-1:16] == KEY);
  assign release_step = key_ok && ctrl_q.en && ctrl_q.halt && core_halted &&
                        wdata[CB_EN] && wdata[CB_STEP] && !wdata[CB_HALT];
  assign step_done = step_pend && ctrl_q.en && core_retire;
  assign hreq_evt  = (key_ok && wdata[CB_EN] && wdata[CB_HALT]) || step_done;

  always_comb begin
    ctrl_d = ctrl_q;
    if (key_ok) ctrl_d = ctrl_t'(wdata[3:0]);
    if (halt_evt || step_done) ctrl_d.halt = 1'b1;
    if (core_reset) ctrl_d.halt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      step_pend  <= 1'b0;
      rst_sticky <= 1'b0;
      ret_sticky <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (core_reset || step_done || (key_ok && !wdata[CB_EN]))
        step_pend <= 1'b0;
      else if (release_step)
        step_pend <= 1'b1;
      rst_sticky <= core_reset  | (rst_sticky & ~rd_en);
      ret_sticky <= core_retire | (ret_sticky & ~rd_en);
    end
  end
endmodule

// File: rtl/dbg_event_flags.sv
module dbg_event_flags #(
  parameter int NUM = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_vec,
  input  logic           clr_en,
  input  logic [NUM-1:0] clr_vec,
  output logic [NUM-1:0] flags
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flags[g] <= 1'b0;
      else if (set_vec[g])            flags[g] <= 1'b1;
      else if (clr_en && clr_vec[g])  flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_monitor_reg.sv
module dbg_monitor_reg
  import dbg_halt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          vc_rst,
  output logic          vc_hf,
  output logic          wpt_en,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_rst <= 1'b0;
      vc_hf  <= 1'b0;
      wpt_en <= 1'b0;
    end else if (wr_en) begin
      vc_rst <= wdata[MB_VC_RST];
      vc_hf  <= wdata[MB_VC_HF];
      wpt_en <= wdata[MB_WPT_EN];
    end
  end

  always_comb begin
    word = '0;
    word[MB_VC_RST] = vc_rst;
    word[MB_VC_HF]  = vc_hf;
    word[MB_WPT_EN] = wpt_en;
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HCSR_OFF = 'h0C0,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 'h000,
  parameter logic [ADDR_W-1:0] MON_OFF  = 'h0CC,
  parameter logic [15:0] KEY = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_bkpt,
  input  logic              core_wpt,
  input  logic              core_ext_req,
  input  logic              core_retire,
  input  logic              core_reset,
  input  logic              core_hardfault,
  input  logic              core_halted,
  input  logic              core_reg_ready,
  output logic              halt_req,
  output logic              step_en,
  output logic              irq_mask,
  output logic              wpt_unit_en
);
  logic wr_ctrl, wr_flag, wr_mon, rd_ctrl;
  logic hreq_evt, rst_sticky, ret_sticky;
  logic vc_rst, vc_hf, core_reset_q, halt_evt;
  ctrl_t ctrl_q;
  logic [NUM_FLAGS-1:0] flag_set, flag_q;
  logic [DW-1:0] ctrl_word, flag_word, mon_word;

  dbg_bus_decode #(
    .ADDR_W(ADDR_W), .HCSR_OFF(HCSR_OFF), .FLAG_OFF(FLAG_OFF), .MON_OFF(MON_OFF)
  ) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .ctrl_word(ctrl_word), .flag_word(flag_word), .mon_word(mon_word),
    .wr_ctrl(wr_ctrl), .wr_flag(wr_flag), .wr_mon(wr_mon), .rd_ctrl(rd_ctrl),
    .rdata(bus_rdata)
  );

  dbg_monitor_reg u_mon (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mon), .wdata(bus_wdata),
    .vc_rst(vc_rst), .vc_hf(vc_hf), .wpt_en(wpt_unit_en), .word(mon_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_reset_q <= 1'b0;
    else        core_reset_q <= core_reset;
  end

  // debug events, qualified by the enable bit
  always_comb begin
    flag_set            = '0;
    flag_set[FL_BKPT]   = ctrl_q.en & core_bkpt;
    flag_set[FL_WPT]    = ctrl_q.en & core_wpt & wpt_unit_en;
    flag_set[FL_EXT]    = ctrl_q.en & core_ext_req;
    flag_set[FL_VCATCH] = ctrl_q.en & ((vc_rst & core_reset_q & ~core_reset) |
                                       (vc_hf & core_hardfault));
    halt_evt            = |flag_set;
    flag_set[FL_HREQ]   = hreq_evt;
  end

  dbg_ctrl_reg #(.KEY(KEY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata), .rd_en(rd_ctrl),
    .halt_evt(halt_evt), .core_reset(core_reset), .core_retire(core_retire),
    .core_halted(core_halted), .ctrl_q(ctrl_q), .hreq_evt(hreq_evt),
    .rst_sticky(rst_sticky), .ret_sticky(ret_sticky)
  );

  dbg_event_flags #(.NUM(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(flag_set), .clr_en(wr_flag),
    .clr_vec(bus_wdata[NUM_FLAGS-1:0]), .flags(flag_q)
  );

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[3:0]        = ctrl_q;
    ctrl_word[SB_READY]   = core_reg_ready;
    ctrl_word[SB_HALTED]  = core_halted;
    ctrl_word[SB_RETIRED] = ret_sticky;
    ctrl_word[SB_RESET]   = rst_sticky;
    flag_word             = '0;
    flag_word[NUM_FLAGS-1:0] = flag_q;
  end

  assign halt_req = ctrl_q.en & ctrl_q.halt;
  assign step_en  = ctrl_q.en & ctrl_q.step;
  assign irq_mask = ctrl_q.en & ctrl_q.mask;
endmodule

// File: rtl/dbg_halt_ctrl_sva.sv
module dbg_halt_ctrl_sva #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HCSR_OFF = 'h0C0,
  parameter logic [15:0] KEY = 16'hA05F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              core_reset,
  input logic              core_retire,
  input logic              halt_req,
  input logic              wpt_unit_en,
  input logic              halt_evt,
  input logic              dbg_en,
  input logic [3:0]        ctrl_bits,
  input logic [4:0]        flags,
  input logic              rst_sticky
);
  assert_key_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == HCSR_OFF && bus_wdata[31:16] != KEY &&
     !halt_evt && !core_retire && !core_reset) |=> $stable(ctrl_bits));

  assert_sticky_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> rst_sticky);

  assert_flags_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_en && !(bus_sel && bus_wr)) |=> $stable(flags));

  assert_wpt_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wpt_unit_en |=> !$rose(flags[2]));

  assert_reset_clears_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !halt_req);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_sva #(
  .ADDR_W(ADDR_W), .HCSR_OFF(HCSR_OFF), .KEY(KEY)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .core_reset(core_reset),
  .core_retire(core_retire), .halt_req(halt_req), .wpt_unit_en(wpt_unit_en),
  .halt_evt(halt_evt), .dbg_en(ctrl_q.en), .ctrl_bits(ctrl_q),
  .flags(flag_q), .rst_sticky(rst_sticky)
);

// File: tb/dbg_halt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_test;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_CTRL = 8'hC0, A_FLAG = 8'h00, A_MON = 8'hCC, A_NONE = 8'hC8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic core_bkpt = 0, core_wpt = 0, core_ext_req = 0, core_retire = 0;
  logic core_reset = 0, core_hardfault = 0, core_halted = 0, core_reg_ready = 0;
  logic halt_req, step_en, irq_mask, wpt_unit_en;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_bkpt(core_bkpt), .core_wpt(core_wpt), .core_ext_req(core_ext_req),
    .core_retire(core_retire), .core_reset(core_reset),
    .core_hardfault(core_hardfault), .core_halted(core_halted),
    .core_reg_ready(core_reg_ready), .halt_req(halt_req), .step_en(step_en),
    .irq_mask(irq_mask), .wpt_unit_en(wpt_unit_en)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse_bkpt();    @(negedge clk); core_bkpt = 1;      @(negedge clk); core_bkpt = 0;      endtask
  task automatic pulse_wpt();     @(negedge clk); core_wpt = 1;       @(negedge clk); core_wpt = 0;       endtask
  task automatic pulse_ext();     @(negedge clk); core_ext_req = 1;   @(negedge clk); core_ext_req = 0;   endtask
  task automatic pulse_hf();      @(negedge clk); core_hardfault = 1; @(negedge clk); core_hardfault = 0; endtask
  task automatic pulse_retire();  @(negedge clk); core_retire = 1;    @(negedge clk); core_retire = 0;    endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_FLAG, v); check("R1 flags", v, 0);
    rd(A_MON, v);  check("R1 mon", v, 0);
    check("R1 outs", {halt_req, step_en, irq_mask, wpt_unit_en}, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(A_CTRL, 32'h0000_0003);
    rd(A_CTRL, v); check("R2 no key", v, 0);
    wr(A_CTRL, 32'hA05E_0003);
    rd(A_CTRL, v); check("R2 bad key", v, 0);
    wr(A_CTRL, 32'hA05F_0003);
    rd(A_CTRL, v); check("R2 key ok", v, 32'h3);
    check("R2 halt_req", halt_req, 1);
    rd(A_FLAG, v); check("R13 halt flag", v, 32'h1);
    wr(A_FLAG, 32'h1F);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(A_CTRL, 32'hA05F_FFFF);
    rd(A_CTRL, v); check("R3 reserved", v, 32'hF);
    check("R5 mask+step", {irq_mask, step_en}, 2'b11);
    core_halted = 1; core_reg_ready = 1;
    rd(A_CTRL, v); check("R3 status", v, 32'h0003_000F);
    core_halted = 0; core_reg_ready = 0;
    wr(A_MON, 32'hFFFF_FFFF);
    rd(A_MON, v); check("R3 mon", v, 32'h0100_0401);
    wr(A_MON, 32'h0);
    rd(A_NONE, v); check("R3 unmapped", v, 0);
    wr(A_CTRL, 32'hA05F_0000);
    wr(A_FLAG, 32'h1F);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(A_CTRL, 32'hA05F_000A);
    rd(A_CTRL, v); check("R5 bits held", v, 32'hA);
    check("R5 no effect", {halt_req, irq_mask}, 0);
    pulse_bkpt();
    rd(A_FLAG, v); check("R6 no capture", v, 0);
    wr(A_CTRL, 32'hA05F_0009);
    check("R5 mask on", {halt_req, irq_mask}, 2'b01);
    wr(A_CTRL, 32'hA05F_0001);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse_bkpt();
    rd(A_FLAG, v); check("R7 bkpt flag", v, 32'h2);
    check("R7 bkpt halt", halt_req, 1);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); check("R6 w0 keeps", v, 32'h2);
    wr(A_FLAG, 32'h2);
    rd(A_FLAG, v); check("R6 w1c", v, 0);
    @(negedge clk);
    core_bkpt = 1; bus_sel = 1; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 32'h2;
    @(negedge clk);
    core_bkpt = 0; bus_sel = 0; bus_wr = 0;
    rd(A_FLAG, v); check("R6 set wins", v, 32'h2);
    wr(A_FLAG, 32'h1F);
    wr(A_CTRL, 32'hA05F_0001);
    pulse_ext();
    rd(A_FLAG, v); check("R7 ext flag", v, 32'h10);
    check("R7 ext halt", halt_req, 1);
    wr(A_FLAG, 32'h1F);
    wr(A_CTRL, 32'hA05F_0001);
  endtask

  task automatic t_wpt();
    logic [31:0] v;
    pulse_wpt();
    rd(A_FLAG, v); check("R8 wpt blocked", v, 0);
    check("R8 no halt", halt_req, 0);
    wr(A_MON, 32'h0100_0000);
    check("R8 unit en", wpt_unit_en, 1);
    pulse_wpt();
    rd(A_FLAG, v); check("R8 wpt flag", v, 32'h4);
    check("R8 wpt halt", halt_req, 1);
    wr(A_MON, 0);
    wr(A_FLAG, 32'h1F);
  endtask

  task automatic t_core_reset();
    logic [31:0] v;
    wr(A_MON, 32'h1);
    wr(A_CTRL, 32'hA05F_0003);
    wr(A_FLAG, 32'h1F);
    @(negedge clk); core_reset = 1;
    @(negedge clk);
    check("R11 halt cleared", halt_req, 0);
    rd(A_CTRL, v); check("R4 reset bit", v & 32'h0200_0000, 32'h0200_0000);
    rd(A_CTRL, v); check("R4 held sets again", v & 32'h0200_0000, 32'h0200_0000);
    core_reset = 0;
    @(negedge clk);
    check("R9 reset catch halt", halt_req, 1);
    rd(A_FLAG, v); check("R9 vcatch flag", v, 32'h8);
    rd(A_CTRL, v); check("R4 last held", v & 32'h0200_0000, 32'h0200_0000);
    rd(A_CTRL, v); check("R4 cleared", v & 32'h0200_0000, 0);
    wr(A_MON, 32'h400);
    wr(A_CTRL, 32'hA05F_0001);
    wr(A_FLAG, 32'h1F);
    pulse_hf();
    check("R10 hf halt", halt_req, 1);
    rd(A_FLAG, v); check("R10 vcatch flag", v, 32'h8);
    wr(A_MON, 0);
    wr(A_FLAG, 32'h1F);
    wr(A_CTRL, 32'hA05F_0001);
  endtask

  task automatic t_retire_step();
    logic [31:0] v;
    pulse_retire();
    check("R12 no step no halt", halt_req, 0);
    rd(A_CTRL, v); check("R4 retired", v & 32'h0100_0000, 32'h0100_0000);
    rd(A_CTRL, v); check("R4 retired clr", v & 32'h0100_0000, 0);
    wr(A_CTRL, 32'hA05F_0007);
    core_halted = 1;
    wr(A_FLAG, 32'h1F);
    wr(A_CTRL, 32'hA05F_0005);
    check("R12 released", {halt_req, step_en}, 2'b01);
    core_halted = 0;
    pulse_retire();
    check("R12 re-halted", halt_req, 1);
    rd(A_FLAG, v); check("R12 step flag", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_key();
    t_layout();
    t_disabled();
    t_events();
    t_wpt();
    t_core_reset();
    t_retire_step();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule